// File: doc/BRIEF.md
# Bus Parity Error Halt/Trap Sequencer

This block lives inside a processor's bus controller. It watches the two parity status lines that a memory slave drives back during a read, remembers a reported error, and turns it into a processor stop followed by a trap. A second source is a halt request from a fast local memory path. Both sources go through one internal "parity error set" term. That term only acts during the CPU's pause cycle. It raises a console flag and stops the processor. When the operator presses continue, the processor does not resume where it stopped. It is sent to the parity trap instead.

The trap is presented as a valid/ready handshake. `trap_valid` rises together with a 9-bit vector. Both stay fixed until the CPU answers with `trap_ready` in the same cycle as `trap_valid`, which is the acceptance. The CPU may stall acceptance for any number of cycles, and `trap_ready` has no effect while no trap is offered. The vector is either the legacy CPU error vector (octal 004) or the newer memory error vector (octal 114). A select input picks between them and is sampled at the moment continue is taken. The instruction datapath, microcode and bus master timing are outside the block. They appear here only as strobes: master sync, slave read, pause, continue and trap-ready.

Top module: `bus_parity_sequencer`

## Requirements
- R1: A bus read reports an error only when `bus_par_a`=1 and `bus_par_b`=0, sampled while `msync` and `slave_rd` are both high. The line pairs 0/0 (no error), 0/1 and 1/1 (reserved) are never errors, and neither is any combination seen while `slave_rd` is low.
- R2: `bus_perr_flag` rises in the clock edge that sees `msync` low after a cycle in which it was high. It is visible one cycle after master sync is removed and never while the data cycle is still active.
- R3: While `bus_perr_flag` is set, a cycle with `pause_cyc` high sets `console_flag` and `halt_req` at the next edge. Without a pause cycle, the flag alone causes no halt.
- R4: `fast_halt_req` high during a pause cycle halts in the same way, with no bus error present.
- R5: `cont_pulse` while halted drops `halt_req` and raises `trap_valid` at the next edge. `cont_pulse` while not halted is ignored.
- R6: `trap_vector` is 9'o004 (bit 2 only) when `cfg_new_vec` is low at continue. It is 9'o114 (bits 2, 3 and 6) when `cfg_new_vec` is high.
- R7: With `cfg_det_dis` high, the bus parity lines are ignored and no bus error is recorded.
- R8: Acceptance (`trap_valid` and `trap_ready` both high) clears `console_flag`, `bus_perr_flag` and `trap_valid` at the next edge. Reset clears all outputs.
- R9: Until acceptance, `trap_valid` stays high and `trap_vector` stays unchanged, even if `cfg_new_vec` changes. `trap_ready` without `trap_valid` has no effect.
- R10: Further errors or pause cycles while a halt or trap is pending merge into that event. After acceptance no second halt follows unless a new error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_det_dis | input | 1 | Disable bus parity detection |
| cfg_new_vec | input | 1 | Select vector 114 instead of 004 |
| msync | input | 1 | Master sync of the bus data cycle |
| slave_rd | input | 1 | Current cycle is a read from a slave |
| bus_par_a | input | 1 | First parity status line |
| bus_par_b | input | 1 | Second parity status line |
| fast_halt_req | input | 1 | Halt request from fast memory path |
| pause_cyc | input | 1 | CPU pause cycle strobe |
| cont_pulse | input | 1 | Continue switch pulse |
| trap_ready | input | 1 | CPU accepts the offered trap |
| bus_perr_flag | output | 1 | Latched bus parity error |
| console_flag | output | 1 | Console flag |
| halt_req | output | 1 | Processor halt request |
| trap_valid | output | 1 | Trap offered |
| trap_vector | output | 9 | Trap vector address |

## Verification
The hardest situation to reach is a second error that arrives while a halt is already pending. It needs a complete halt to be built first, then a fresh faulty bus read and another pause cycle during the stop, then continue and an acceptance that is delayed. The merge scenario drives exactly that sequence. It then issues one more pause cycle with no error to show that no second halt was queued. The stalled-acceptance scenario holds `trap_ready` low for several cycles while toggling the vector select, which checks that the vector is held.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int VEC_W = 9;

  typedef enum logic [1:0] {
    SEQ_RUN    = 2'd0,
    SEQ_HALTED = 2'd1,
    SEQ_TRAP   = 2'd2
  } seq_state_t;

  localparam int LEGACY_BIT = 2;
  localparam int NEW_BIT_LO = 3;
  localparam int NEW_BIT_HI = 6;

  function automatic logic [VEC_W-1:0] make_vector(input logic new_sel);
    logic [VEC_W-1:0] v;
    v = '0;
    v[LEGACY_BIT] = 1'b1;
    v[NEW_BIT_LO] = new_sel;
    v[NEW_BIT_HI] = new_sel;
    return v;
  endfunction
endpackage

// File: rtl/bps_bus_flag.sv
module bps_bus_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic det_dis,
  input  logic msync,
  input  logic slave_rd,
  input  logic par_a,
  input  logic par_b,
  input  logic clr,
  output logic flag
);
  logic msync_q;
  logic err_seen;
  logic line_err;
  logic sync_fall;

  assign line_err  = msync && slave_rd && !det_dis && par_a && !par_b;
  assign sync_fall = msync_q && !msync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msync_q  <= 1'b0;
      err_seen <= 1'b0;
      flag     <= 1'b0;
    end else begin
      msync_q <= msync;
      if (clr) begin
        err_seen <= 1'b0;
        flag     <= 1'b0;
      end else if (sync_fall) begin
        err_seen <= 1'b0;
        if (err_seen) flag <= 1'b1;
      end else if (line_err) begin
        err_seen <= 1'b1;
      end
    end
  end

  AST_FLAG_AFTER_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (!$past(msync) && !msync_q)); // R2
  AST_DISABLED_NOTHING_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (det_dis && !err_seen) |=> !err_seen); // R7
endmodule

// File: rtl/bps_halt_ctrl.sv
module bps_halt_ctrl
  import bps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pe_set,
  input  logic cont,
  input  logic accept,
  output logic console,
  output logic halt_req,
  output logic trap_pend,
  output logic load_vec
);
  seq_state_t state;

  assign halt_req  = (state == SEQ_HALTED);
  assign trap_pend = (state == SEQ_TRAP);
  assign load_vec  = halt_req && cont;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_RUN;
      console <= 1'b0;
    end else begin
      unique case (state)
        SEQ_RUN: if (pe_set) begin
          state   <= SEQ_HALTED;
          console <= 1'b1;
        end
        SEQ_HALTED: if (cont) state <= SEQ_TRAP;
        SEQ_TRAP: if (accept) begin
          state   <= SEQ_RUN;
          console <= 1'b0;
        end
        default: state <= SEQ_RUN;
      endcase
    end
  end

  AST_HALT_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(pe_set)); // R3
  AST_TRAP_NEEDS_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_pend) |-> ($past(cont) && $past(halt_req))); // R5
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend && accept) |=> (!console && !trap_pend)); // R8
  AST_HALT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !cont) |=> halt_req); // R10
endmodule

// File: rtl/bps_vector_gen.sv
module bps_vector_gen
  import bps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             new_sel,
  output logic [VEC_W-1:0] vector
);
  always_ff @(posedge clk) begin
    if (!rst_n) vector <= '0;
    else if (load) vector <= make_vector(new_sel);
  end
endmodule

// File: rtl/bus_parity_sequencer.sv
module bus_parity_sequencer
  import bps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_det_dis,
  input  logic             cfg_new_vec,
  input  logic             msync,
  input  logic             slave_rd,
  input  logic             bus_par_a,
  input  logic             bus_par_b,
  input  logic             fast_halt_req,
  input  logic             pause_cyc,
  input  logic             cont_pulse,
  input  logic             trap_ready,
  output logic             bus_perr_flag,
  output logic             console_flag,
  output logic             halt_req,
  output logic             trap_valid,
  output logic [VEC_W-1:0] trap_vector
);
  logic pe_set;
  logic accept;
  logic load_vec;
  logic [VEC_W-1:0] vec_q;

  assign pe_set = pause_cyc && (bus_perr_flag || fast_halt_req);
  assign accept = trap_valid && trap_ready;

  bps_bus_flag u_flag (
    .clk(clk), .rst_n(rst_n), .det_dis(cfg_det_dis), .msync(msync),
    .slave_rd(slave_rd), .par_a(bus_par_a), .par_b(bus_par_b),
    .clr(accept), .flag(bus_perr_flag)
  );

  bps_halt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pe_set(pe_set), .cont(cont_pulse),
    .accept(accept), .console(console_flag), .halt_req(halt_req),
    .trap_pend(trap_valid), .load_vec(load_vec)
  );

  bps_vector_gen u_vec (
    .clk(clk), .rst_n(rst_n), .load(load_vec), .new_sel(cfg_new_vec),
    .vector(vec_q)
  );

  assign trap_vector = trap_valid ? vec_q : '0;

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_ready) |=> (trap_valid && $stable(trap_vector))); // R9
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_vector == 9'o004 || trap_vector == 9'o114)); // R6
  AST_FAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_cyc && fast_halt_req && !console_flag) |=> (halt_req && console_flag)); // R4
endmodule

// File: tb/bus_parity_sequencer_bench.sv
module bus_parity_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_det_dis = 0, cfg_new_vec = 0, msync = 0, slave_rd = 0;
  logic bus_par_a = 0, bus_par_b = 0, fast_halt_req = 0, pause_cyc = 0;
  logic cont_pulse = 0, trap_ready = 0;
  logic bus_perr_flag, console_flag, halt_req, trap_valid;
  logic [8:0] trap_vector;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_parity_sequencer u_bus_parity_sequencer (.*);

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic rd, input logic a, input logic b, input logic exp_now);
    msync = 1; slave_rd = rd; bus_par_a = a; bus_par_b = b;
    @(negedge clk);
    msync = 0; slave_rd = 0; bus_par_a = 0; bus_par_b = 0;
    chk("R2 flag during cycle", {8'd0, bus_perr_flag}, {8'd0, exp_now});
    @(negedge clk);
  endtask

  task automatic strobe_pause(); pause_cyc = 1; @(negedge clk); pause_cyc = 0; endtask
  task automatic strobe_cont();  cont_pulse = 1; @(negedge clk); cont_pulse = 0; endtask
  task automatic strobe_ready(); trap_ready = 1; @(negedge clk); trap_ready = 0; endtask

  task automatic t_reset();
    chk("R8 reset console", {8'd0, console_flag}, 9'd0);
    chk("R8 reset halt", {8'd0, halt_req}, 9'd0);
    chk("R8 reset trap", {8'd0, trap_valid}, 9'd0);
    chk("R8 reset flag", {8'd0, bus_perr_flag}, 9'd0);
  endtask

  task automatic t_decode();
    bus_read(1, 0, 0, 0); chk("R1 00 none", {8'd0, bus_perr_flag}, 9'd0);
    bus_read(1, 0, 1, 0); chk("R1 01 reserved", {8'd0, bus_perr_flag}, 9'd0);
    bus_read(1, 1, 1, 0); chk("R1 11 reserved", {8'd0, bus_perr_flag}, 9'd0);
    bus_read(0, 1, 0, 0); chk("R1 non-read", {8'd0, bus_perr_flag}, 9'd0);
    bus_read(1, 1, 0, 0); chk("R2 flag after sync drop", {8'd0, bus_perr_flag}, 9'd1);
    repeat (3) @(negedge clk);
    chk("R3 no halt without pause", {8'd0, halt_req}, 9'd0);
  endtask

  task automatic t_halt_legacy();
    cfg_new_vec = 0;
    strobe_pause();
    chk("R3 console set", {8'd0, console_flag}, 9'd1);
    chk("R3 halt set", {8'd0, halt_req}, 9'd1);
    strobe_cont();
    chk("R5 trap valid", {8'd0, trap_valid}, 9'd1);
    chk("R5 halt dropped", {8'd0, halt_req}, 9'd0);
    chk("R6 legacy vector", trap_vector, 9'o004);
    strobe_ready();
    chk("R8 ack clears trap", {8'd0, trap_valid}, 9'd0);
    chk("R8 ack clears console", {8'd0, console_flag}, 9'd0);
    chk("R8 ack clears flag", {8'd0, bus_perr_flag}, 9'd0);
  endtask

  task automatic t_fast_new();
    strobe_cont();
    chk("R5 cont ignored when running", {8'd0, trap_valid}, 9'd0);
    strobe_ready();
    chk("R9 ready without valid", {8'd0, console_flag | halt_req}, 9'd0);
    fast_halt_req = 1; strobe_pause(); fast_halt_req = 0;
    chk("R4 fast halt", {8'd0, halt_req}, 9'd1);
    chk("R4 fast console", {8'd0, console_flag}, 9'd1);
    cfg_new_vec = 1;
    strobe_cont();
    chk("R6 new vector", trap_vector, 9'o114);
    cfg_new_vec = 0;
    repeat (4) @(negedge clk);
    chk("R9 held valid", {8'd0, trap_valid}, 9'd1);
    chk("R9 held vector", trap_vector, 9'o114);
    strobe_ready();
    chk("R8 cleared", {8'd0, trap_valid}, 9'd0);
  endtask

  task automatic t_disable();
    cfg_det_dis = 1;
    bus_read(1, 1, 0, 0);
    chk("R7 disabled flag", {8'd0, bus_perr_flag}, 9'd0);
    strobe_pause();
    chk("R7 disabled no halt", {8'd0, halt_req}, 9'd0);
    cfg_det_dis = 0;
  endtask

  task automatic t_merge();
    bus_read(1, 1, 0, 0);
    strobe_pause();
    chk("R10 first halt", {8'd0, halt_req}, 9'd1);
    bus_read(1, 1, 0, 1);
    strobe_pause();
    chk("R10 still one halt", {8'd0, halt_req}, 9'd1);
    strobe_cont();
    chk("R10 trap", {8'd0, trap_valid}, 9'd1);
    repeat (2) @(negedge clk);
    strobe_ready();
    chk("R10 flag cleared", {8'd0, bus_perr_flag}, 9'd0);
    strobe_pause();
    chk("R10 no queued halt", {8'd0, halt_req}, 9'd0);
    chk("R10 no queued console", {8'd0, console_flag}, 9'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_halt_legacy();
    t_fast_new();
    t_disable();
    t_merge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule